// File: doc/BRIEF.md
# Link Training Watchdog With Stuck Speed-Change Recovery

This block supervises a serial link after its training state machine has been enabled. Once `start` is pulsed it evaluates the link at a fixed interval by decoding two debug status words. A link counts as established only when its "up" flag is set and its "training" flag is clear. If no evaluation succeeds within a bounded number of tries, the block declares the link failed. Both results are sticky until the next `start`.

While it polls, the block also watches for a known stall in the speed change. The stall is the training state machine parked in the receiver-lock recovery state while the PHY reports no valid receive data. When the block sees the stall, it runs a recovery sequence on a PHY receive-override register, using abstract read and write requests with an acknowledge handshake:
- read the register, then write it back with the data-enable and PLL-enable override bits forced on;
- wait a fixed hold time;
- read the register again, then write it back with both bits forced off.

The recovery runs alongside the polling and does not pause it.

All intervals are parameters counted in clock cycles: the polling period, the number of tries and the hold time.

Top module: `lnk_train_guard`

## Requirements
- R1: After reset `linkUp`, `linkFail`, `ovrRdReq` and `ovrWrReq` are all low.
- R2: An evaluation finds the link good only when `dbgWord1` bit 4 (up flag) is 1 and `dbgWord1` bit 29 (training flag) is 0. `linkUp` is then high from the clock edge of that evaluation on.
- R3: The first evaluation takes place on the clock edge after the edge that accepts `start`. Further evaluations follow every `POLL_CYCLES` cycles while the link is neither good nor failed.
- R4: A failed evaluation increments a try count. `linkFail` rises at the edge of the `MAX_CHECKS`-th failed evaluation, and evaluation then stops.
- R5: `linkUp` and `linkFail` are never both high, and each holds its value whatever the debug inputs do. A new `start` clears both and restarts the evaluations and the try count.
- R6: A recovery begins only at a failed, non-final evaluation that sees `dbgWord0[5:0]` equal to 0x0D while `rxStatus` bit 0 is 0. Any other state value, or `rxStatus` bit 0 equal to 1, causes no override access.
- R7: A recovery consists of four accesses in this order:
  - a read;
  - a write of the read value with bits 5 and 3 set;
  - after `HOLD_CYCLES` cycles, a second read;
  - a write of that second value with bits 5 and 3 cleared.
  All other bits are taken unchanged from the read that precedes each write.
- R8: A request stays high until its acknowledge is seen, and a read request and a write request are never high together.
- R9: While a recovery is in progress, evaluations and the try count continue, but a further stall does not start a second recovery. A stall seen after the recovery ends may start a new one.
- R10: A started recovery always runs to its final clearing write, even if the link is declared up or failed meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: clear results and begin polling |
| dbgWord0 | input | DBG_W | Debug word holding the training state in bits [5:0] |
| dbgWord1 | input | DBG_W | Debug word holding the up flag (bit 4) and training flag (bit 29) |
| rxStatus | input | PHY_W | PHY receive status; bit 0 is receive-data valid |
| ovrRdReq | output | 1 | Read request to the receive-override register |
| ovrRdAck | input | 1 | Read acknowledge; `ovrRdData` is valid with it |
| ovrRdData | input | PHY_W | Read data of the override register |
| ovrWrReq | output | 1 | Write request to the override register |
| ovrWrData | output | PHY_W | Write data for the override register |
| ovrWrAck | input | 1 | Write acknowledge |
| linkUp | output | 1 | Sticky: link found established |
| linkFail | output | 1 | Sticky: tries exhausted without success |

## Verification
Assertions check on every cycle that the two results are exclusive and sticky, and that the try count never passes its limit. They also check the access handshake: read and write requests are exclusive and each is held until its acknowledge. Finally, they check that a recovery begins only right after an evaluation that saw the stall, and that the override bits are set or cleared in the captured value. The bench scenarios show the cycle-exact evaluation schedule and the failure edge. They also show that a recovery's writes carry the correct values even when the register changes during the hold, and that only one recovery runs at a time. The remaining behaviours shown by the scenarios are that an active recovery still completes after the link is declared failed, and that a non-stalled state causes no access at all.

// File: rtl/lnk_train_pkg.sv
package lnk_train_pkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic clrStatus;
    logic clrChecks;
    logic incChecks;
    logic setUp;
    logic setFail;
    logic loadPoll;
    logic decPoll;
    logic loadHold;
    logic decHold;
    logic capSet;
    logic capClr;
  } ctrlStrobe_t;

  // Conditions reported by the datapath to the control
  typedef struct packed {
    logic linkGood;
    logic stuck;
    logic pollDone;
    logic holdDone;
    logic checksLast;
  } dpStatus_t;

endpackage

// File: rtl/lnk_train_dp.sv
module lnk_train_dp
  import lnk_train_pkg::*;
#(
  parameter int DBG_W       = 32,
  parameter int PHY_W       = 16,
  parameter int STATE_W     = 6,
  parameter int STUCK_STATE = 13,
  parameter int UP_BIT      = 4,
  parameter int TRAIN_BIT   = 29,
  parameter int DATA_EN_BIT = 5,
  parameter int PLL_EN_BIT  = 3,
  parameter int POLL_CYCLES = 1000,
  parameter int MAX_CHECKS  = 2000,
  parameter int HOLD_CYCLES = 300000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [DBG_W-1:0] dbgWord0,
  input  logic [DBG_W-1:0] dbgWord1,
  input  logic [PHY_W-1:0] rxStatus,
  input  logic [PHY_W-1:0] ovrRdData,
  output logic [PHY_W-1:0] ovrWrData,
  output logic             linkUp,
  output logic             linkFail,
  output dpStatus_t        stat
);

  localparam int POLL_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
  localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam int CHK_W  = $clog2(MAX_CHECKS + 1);
  localparam logic [POLL_W-1:0] POLL_LOAD  = POLL_W'(POLL_CYCLES - 2);
  localparam logic [HOLD_W-1:0] HOLD_LOAD  = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [CHK_W-1:0]  LAST_CHECK = CHK_W'(MAX_CHECKS - 1);
  localparam logic [CHK_W-1:0]  CHK_LIMIT  = CHK_W'(MAX_CHECKS);
  localparam logic [STATE_W-1:0] STUCK_CODE = STATE_W'(STUCK_STATE);
  localparam logic [PHY_W-1:0] OVR_MASK =
    PHY_W'((1 << DATA_EN_BIT) | (1 << PLL_EN_BIT));

  logic [POLL_W-1:0] pollCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [CHK_W-1:0]  checkCnt;
  logic [PHY_W-1:0]  ovrData;

  // Decode of the debug words and receive status
  always_comb begin
    stat.linkGood   = dbgWord1[UP_BIT] & ~dbgWord1[TRAIN_BIT];
    stat.stuck      = (dbgWord0[STATE_W-1:0] == STUCK_CODE) & ~rxStatus[0];
    stat.pollDone   = (pollCnt == '0);
    stat.holdDone   = (holdCnt == '0);
    stat.checksLast = (checkCnt == LAST_CHECK);
  end

  // Polling interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pollCnt <= '0;
    else if (strb.loadPoll) pollCnt <= POLL_LOAD;
    else if (strb.decPoll)  pollCnt <= pollCnt - 1'b1;
  end

  // Override hold timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdCnt <= '0;
    else if (strb.loadHold) holdCnt <= HOLD_LOAD;
    else if (strb.decHold)  holdCnt <= holdCnt - 1'b1;
  end

  // Try counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               checkCnt <= '0;
    else if (strb.clrChecks) checkCnt <= '0;
    else if (strb.incChecks) checkCnt <= checkCnt + 1'b1;
  end

  // Sticky results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkUp   <= 1'b0;
      linkFail <= 1'b0;
    end else if (strb.clrStatus) begin
      linkUp   <= 1'b0;
      linkFail <= 1'b0;
    end else begin
      if (strb.setUp)   linkUp   <= 1'b1;
      if (strb.setFail) linkFail <= 1'b1;
    end
  end

  // Read-modify-write data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovrData <= '0;
    else if (strb.capSet) ovrData <= ovrRdData | OVR_MASK;
    else if (strb.capClr) ovrData <= ovrRdData & ~OVR_MASK;
  end

  assign ovrWrData = ovrData;

  p_result_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(linkUp && linkFail));

  p_up_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkUp && !strb.clrStatus |=> linkUp);

  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkFail && !strb.clrStatus |=> linkFail);

  p_check_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    checkCnt <= CHK_LIMIT);

  p_bits_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capSet |=> ((ovrWrData & OVR_MASK) == OVR_MASK));

  p_bits_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capClr |=> ((ovrWrData & OVR_MASK) == '0));

endmodule

// File: rtl/lnk_train_ctrl.sv
module lnk_train_ctrl
  import lnk_train_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        ovrRdAck,
  input  logic        ovrWrAck,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        ovrRdReq,
  output logic        ovrWrReq
);

  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_EVAL} pollSt_t;
  typedef enum logic [2:0] {R_IDLE, R_RD_SET, R_WR_SET, R_HOLD,
                            R_RD_CLR, R_WR_CLR} recSt_t;

  pollSt_t pollState, pollNext;
  recSt_t  recState, recNext;
  logic    kick;

  always_comb begin
    strb     = '0;
    pollNext = pollState;
    recNext  = recState;
    kick     = 1'b0;

    // Link evaluation schedule
    case (pollState)
      P_WAIT: begin
        if (stat.pollDone) pollNext = P_EVAL;
        else               strb.decPoll = 1'b1;
      end
      P_EVAL: begin
        if (stat.linkGood) begin
          strb.setUp = 1'b1;
          pollNext   = P_IDLE;
        end else begin
          strb.incChecks = 1'b1;
          if (stat.checksLast) begin
            strb.setFail = 1'b1;
            pollNext     = P_IDLE;
          end else begin
            strb.loadPoll = 1'b1;
            pollNext      = P_WAIT;
            kick          = stat.stuck && (recState == R_IDLE);
          end
        end
      end
      default: ;
    endcase

    // A start pulse overrides the evaluation in any state
    if (start) begin
      strb.clrStatus = 1'b1;
      strb.clrChecks = 1'b1;
      strb.incChecks = 1'b0;
      strb.setUp     = 1'b0;
      strb.setFail   = 1'b0;
      strb.loadPoll  = 1'b0;
      strb.decPoll   = 1'b0;
      kick           = 1'b0;
      pollNext       = P_EVAL;
    end

    // Override recovery sequence, independent of the schedule
    case (recState)
      R_IDLE:   if (kick) recNext = R_RD_SET;
      R_RD_SET: if (ovrRdAck) begin
                  strb.capSet = 1'b1;
                  recNext     = R_WR_SET;
                end
      R_WR_SET: if (ovrWrAck) begin
                  strb.loadHold = 1'b1;
                  recNext       = R_HOLD;
                end
      R_HOLD:   if (stat.holdDone) recNext = R_RD_CLR;
                else               strb.decHold = 1'b1;
      R_RD_CLR: if (ovrRdAck) begin
                  strb.capClr = 1'b1;
                  recNext     = R_WR_CLR;
                end
      R_WR_CLR: if (ovrWrAck) recNext = R_IDLE;
      default:  recNext = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollState <= P_IDLE;
      recState  <= R_IDLE;
    end else begin
      pollState <= pollNext;
      recState  <= recNext;
    end
  end

  assign ovrRdReq = (recState == R_RD_SET) || (recState == R_RD_CLR);
  assign ovrWrReq = (recState == R_WR_SET) || (recState == R_WR_CLR);

  p_req_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ovrRdReq && ovrWrReq));

  p_rd_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovrRdReq && !ovrRdAck |=> ovrRdReq);

  p_wr_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovrWrReq && !ovrWrAck |=> ovrWrReq);

  p_kick_on_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrRdReq) && (recState == R_RD_SET)
      |-> $past(pollState == P_EVAL && stat.stuck && !stat.linkGood));

  p_single_recovery_r9: assert property (@(posedge clk) disable iff (!rstN)
    (recState != R_IDLE) && (recState != R_WR_CLR) |=> (recState != R_IDLE));

endmodule

// File: rtl/lnk_train_guard.sv
module lnk_train_guard
  import lnk_train_pkg::*;
#(
  parameter int DBG_W       = 32,
  parameter int PHY_W       = 16,
  parameter int STATE_W     = 6,
  parameter int STUCK_STATE = 13,
  parameter int UP_BIT      = 4,
  parameter int TRAIN_BIT   = 29,
  parameter int DATA_EN_BIT = 5,
  parameter int PLL_EN_BIT  = 3,
  parameter int POLL_CYCLES = 1000,
  parameter int MAX_CHECKS  = 2000,
  parameter int HOLD_CYCLES = 300000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DBG_W-1:0] dbgWord0,
  input  logic [DBG_W-1:0] dbgWord1,
  input  logic [PHY_W-1:0] rxStatus,
  output logic             ovrRdReq,
  input  logic             ovrRdAck,
  input  logic [PHY_W-1:0] ovrRdData,
  output logic             ovrWrReq,
  output logic [PHY_W-1:0] ovrWrData,
  input  logic             ovrWrAck,
  output logic             linkUp,
  output logic             linkFail
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  lnk_train_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ovrRdAck (ovrRdAck),
    .ovrWrAck (ovrWrAck),
    .stat     (stat),
    .strb     (strb),
    .ovrRdReq (ovrRdReq),
    .ovrWrReq (ovrWrReq)
  );

  lnk_train_dp #(
    .DBG_W       (DBG_W),
    .PHY_W       (PHY_W),
    .STATE_W     (STATE_W),
    .STUCK_STATE (STUCK_STATE),
    .UP_BIT      (UP_BIT),
    .TRAIN_BIT   (TRAIN_BIT),
    .DATA_EN_BIT (DATA_EN_BIT),
    .PLL_EN_BIT  (PLL_EN_BIT),
    .POLL_CYCLES (POLL_CYCLES),
    .MAX_CHECKS  (MAX_CHECKS),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dbgWord0  (dbgWord0),
    .dbgWord1  (dbgWord1),
    .rxStatus  (rxStatus),
    .ovrRdData (ovrRdData),
    .ovrWrData (ovrWrData),
    .linkUp    (linkUp),
    .linkFail  (linkFail),
    .stat      (stat)
  );

endmodule

// File: tb/lnk_train_guard_tb_top.sv
module lnk_train_guard_tb_top;

  localparam int POLL = 8;
  localparam int MAXC = 6;
  localparam int HOLD = 20;
  localparam logic [31:0] UP_ONLY  = 32'h0000_0010;
  localparam logic [31:0] UP_TRAIN = 32'h2000_0010;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dbgWord0 = '0;
  logic [31:0] dbgWord1 = '0;
  logic [15:0] rxStatus = '0;
  logic        ovrRdReq, ovrWrReq;
  logic        ovrRdAck = 1'b0;
  logic        ovrWrAck = 1'b0;
  logic [15:0] ovrRdData = '0;
  logic [15:0] ovrWrData;
  logic        linkUp, linkFail;

  int checks = 0;
  int failures = 0;
  int rdCount = 0;
  int wrCount = 0;
  int ackDelay = 0;
  int waitCnt = 0;
  logic [15:0] modelReg = '0;
  logic [15:0] expQ[$];

  always #5 clk = ~clk;

  lnk_train_guard #(
    .POLL_CYCLES (POLL),
    .MAX_CHECKS  (MAXC),
    .HOLD_CYCLES (HOLD)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dbgWord0  (dbgWord0),
    .dbgWord1  (dbgWord1),
    .rxStatus  (rxStatus),
    .ovrRdReq  (ovrRdReq),
    .ovrRdAck  (ovrRdAck),
    .ovrRdData (ovrRdData),
    .ovrWrReq  (ovrWrReq),
    .ovrWrData (ovrWrData),
    .ovrWrAck  (ovrWrAck),
    .linkUp    (linkUp),
    .linkFail  (linkFail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic stepTo(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Responder and scoreboard monitor for the override register
  always @(negedge clk) begin
    ovrRdAck = 1'b0;
    ovrWrAck = 1'b0;
    if (rstN) begin
      if (ovrRdReq && ovrWrReq) begin
        checks++;
        failures++;
        $display("FAIL R8 both requests high actual=1 expected=0");
      end
      if (ovrRdReq) begin
        if (waitCnt >= ackDelay) begin
          ovrRdAck  = 1'b1;
          ovrRdData = modelReg;
          rdCount++;
          waitCnt = 0;
        end else waitCnt++;
      end else if (ovrWrReq) begin
        if (waitCnt >= ackDelay) begin
          ovrWrAck = 1'b1;
          checks++;
          if (expQ.size() == 0) begin
            failures++;
            $display("FAIL R7 unexpected write actual=0x%0h expected=none", ovrWrData);
          end else begin
            logic [15:0] e;
            e = expQ.pop_front();
            if (ovrWrData !== e) begin
              failures++;
              $display("FAIL R7 write data actual=0x%0h expected=0x%0h", ovrWrData, e);
            end
          end
          modelReg = ovrWrData;
          wrCount++;
          waitCnt = 0;
        end else waitCnt++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int wr0, rd0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!linkUp && !linkFail, "R1 results low in reset", {linkUp, linkFail}, 0);
    rstN = 1'b1;
    stepTo(2);
    check(!ovrRdReq && !ovrWrReq && !linkUp && !linkFail,
          "R1 idle after reset", {ovrRdReq, ovrWrReq, linkUp, linkFail}, 0);

    // R2 immediate link up
    dbgWord1 = UP_ONLY;
    pulseStart();
    check(!linkUp, "R2 not up before first evaluation", linkUp, 0);
    stepTo(1);
    check(linkUp, "R2 up at first evaluation", linkUp, 1);

    // R2/R3 training flag blocks link up; state 0x11 is not a stall (R6)
    dbgWord1 = UP_TRAIN;
    dbgWord0 = 32'h11;
    rxStatus = 16'h0;
    pulseStart();
    check(!linkUp, "R5 start clears linkUp", linkUp, 0);
    stepTo(1);
    check(!linkUp, "R2 training flag keeps link down", linkUp, 0);
    dbgWord1 = UP_ONLY;
    stepTo(POLL - 1);
    check(!linkUp, "R3 no evaluation before period", linkUp, 0);
    stepTo(1);
    check(linkUp, "R3 second evaluation one period later", linkUp, 1);

    // R5 sticky up
    dbgWord1 = '0;
    stepTo(20);
    check(linkUp && !linkFail, "R5 linkUp sticky", {linkUp, linkFail}, 2);

    // R4 failure timing; rx valid high means no recovery (R6)
    dbgWord0 = 32'h0D;
    rxStatus = 16'h0001;
    wr0 = wrCount;
    rd0 = rdCount;
    pulseStart();
    stepTo(1 + (MAXC - 1) * POLL - 1);
    check(!linkFail, "R4 no fail before last try", linkFail, 0);
    stepTo(1);
    check(linkFail && !linkUp, "R4 fail at last try", {linkUp, linkFail}, 1);
    dbgWord1 = UP_ONLY;
    stepTo(20);
    check(linkFail && !linkUp, "R5 linkFail sticky, no further evaluation",
          {linkUp, linkFail}, 1);
    check(wrCount == wr0 && rdCount == rd0, "R6 no access with rx valid",
          wrCount - wr0 + rdCount - rd0, 0);

    // R7 recovery keeps other bits, uses second read; slow acknowledge (R8)
    dbgWord1 = '0;
    dbgWord0 = 32'hC0D;
    rxStatus = 16'hFFFE;
    ackDelay = 3;
    modelReg = 16'h0F14;
    wr0 = wrCount;
    expQ.push_back(16'h0F3C);
    pulseStart();
    check(!linkFail, "R5 start clears linkFail", linkFail, 0);
    for (int i = 0; i < 200 && wrCount == wr0; i++) @(negedge clk);
    dbgWord0 = 32'h0;
    @(negedge clk);
    modelReg = 16'hFFFF;
    expQ.push_back(16'hFFD7);
    for (int i = 0; i < 200 && wrCount < wr0 + 2; i++) @(negedge clk);
    stepTo(60);
    check(wrCount == wr0 + 2 && expQ.size() == 0, "R7 two writes per recovery",
          wrCount - wr0, 2);

    // R9/R10 persistent stall: one recovery at a time, completes after fail
    ackDelay = 0;
    modelReg = 16'h0100;
    dbgWord0 = 32'h0D;
    rxStatus = 16'h0;
    dbgWord1 = '0;
    wr0 = wrCount;
    rd0 = rdCount;
    repeat (2) begin
      expQ.push_back(16'h0128);
      expQ.push_back(16'h0100);
    end
    pulseStart();
    stepTo(1 + (MAXC - 1) * POLL - 1);
    check(!linkFail, "R9 tries keep counting during recovery", linkFail, 0);
    stepTo(1);
    check(linkFail, "R9 fail on schedule during recovery", linkFail, 1);
    check(wrCount - wr0 < 4, "R10 second recovery still open at fail",
          wrCount - wr0, 3);
    stepTo(30);
    check(wrCount == wr0 + 4 && rdCount == rd0 + 4,
          "R9 exactly two recoveries", wrCount - wr0 + rdCount - rd0, 8);
    check(expQ.size() == 0 && !ovrRdReq && !ovrWrReq,
          "R10 recovery completed after fail", expQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule